// File: doc/BRIEF.md
# Framed Symbol Serializer with Sync Payload

This block turns parallel payload words into a framed serial bit stream for a fixed-latency timing link. Every symbol is one start bit, the payload word sent most significant bit first, and one stop bit. The payload goes out exactly as presented, with no encoding or scrambling. Because the start bit is high and the stop bit is low, every boundary between two symbols carries a rising edge. A remote receiver can use that edge to hold its alignment.

The block runs on one clock, and a bit-rate enable `bit_en` paces it. Each enabled clock edge moves the line forward by one bit, so a symbol takes `PAYLOAD_W + 2` enabled edges. The inputs are sampled once per symbol, on the enabled edge that emits the start bit. At that edge, a raised `sync_req` replaces the payload with the alignment pattern: the upper half of the bits are ones and the lower half are zeros. If no valid word is present, the block sends a framed all-zero payload. The time from the sampling edge to each serial bit is the same for every symbol and never changes after reset.

Top module: `fss_serializer`

## Requirements
- R1: During and directly after a synchronous reset, `ser_out` is 0. The first enabled edge after reset is the start-bit edge of a new symbol.
- R2: Each symbol lasts 20 enabled edges (for PAYLOAD_W = 18). The start bit is 1, the 18 payload bits follow, and the stop bit is 0.
- R3: Payload bits are sent most significant bit first, directly after the start bit. Bit 17 is sent first and bit 0 is sent last.
- R4: If `sync_req` is 1 at the sampling edge, the payload is 18'h3FE00 (nine ones, then nine zeros), whatever the values of `valid` and `data`.
- R5: If `sync_req` is 0 and `valid` is 0 at the sampling edge, the payload is all zeros, whatever the value of `data`.
- R6: `data`, `valid` and `sync_req` are sampled only on the start-bit edge. Changes to them during the rest of the symbol do not alter the bits on the line.
- R7: On a clock edge where `bit_en` is 0, `ser_out` keeps its value.
- R8: The start bit appears on `ser_out` right after the sampling edge. Payload bit i appears after the (18 - i)-th enabled edge that follows the sampling edge. This latency is the same for every symbol.
- R9: Symbols follow each other with no gap. Each stop bit is followed by the next start bit, so `ser_out` rises at every symbol boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit-rate enable; one serial bit per enabled edge |
| data | input | PAYLOAD_W | Payload word |
| valid | input | 1 | Payload word present |
| sync_req | input | 1 | Send the alignment pattern in place of the payload |
| ser_out | output | 1 | Registered serial line output |

## Verification
If the bit-position counter is wrong, the start or stop bit lands in the wrong slot. The bench sees that on the first symbol after the fault, because it predicts the level of every bit slot. A corrupted shift register or payload selector shows up as a mismatch in the payload bit where the error first enters, which is at most 18 enabled edges after the sampling edge. The bench changes the inputs in the middle of every symbol. A design that samples them more than once therefore corrupts the tail of that same symbol. Gaps in `bit_en` reveal any output change that happens without an enable on the next clock edge.

// File: rtl/fss_pkg.sv
package fss_pkg;
  localparam logic START_LVL = 1'b1;
  localparam logic STOP_LVL  = 1'b0;

  // Alignment payload: upper half ones, lower half zeros.
  function automatic logic [63:0] sync_pattern(input int unsigned width);
    logic [63:0] pat;
    pat = '0;
    for (int unsigned k = 0; k < 64; k++) begin
      if (k < width && k >= width / 2) pat[k] = 1'b1;
    end
    return pat;
  endfunction
endpackage

// File: rtl/fss_bit_counter.sv
module fss_bit_counter #(
  parameter int SYM_W = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  output logic load,
  output logic last
);
  localparam int PW = $clog2(SYM_W);
  localparam logic [PW-1:0] LAST_POS = PW'(SYM_W - 1);

  logic [PW-1:0] pos;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos <= '0;
    end else if (bit_en) begin
      pos <= (pos == LAST_POS) ? '0 : pos + 1'b1;
    end
  end

  assign load = bit_en && (pos == '0);
  assign last = bit_en && (pos == LAST_POS);

  p_wrap_r9: assert property (@(posedge clk) disable iff (rst)
    last |=> (pos == '0));
  p_pos_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(pos));
endmodule

// File: rtl/fss_payload_mux.sv
module fss_payload_mux #(
  parameter int PAYLOAD_W = 18
) (
  input  logic [PAYLOAD_W-1:0] data,
  input  logic                 valid,
  input  logic                 sync_req,
  output logic [PAYLOAD_W-1:0] payload
);
  import fss_pkg::*;
  localparam logic [63:0] SYNC_FULL = sync_pattern(PAYLOAD_W);
  localparam logic [PAYLOAD_W-1:0] SYNC_WORD = SYNC_FULL[PAYLOAD_W-1:0];

  always_comb begin
    if (sync_req)   payload = SYNC_WORD;
    else if (valid) payload = data;
    else            payload = '0;
  end
endmodule

// File: rtl/fss_shifter.sv
module fss_shifter #(
  parameter int PAYLOAD_W = 18
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bit_en,
  input  logic                 load,
  input  logic [PAYLOAD_W-1:0] payload,
  output logic                 ser_out
);
  import fss_pkg::*;
  localparam int SH_W = PAYLOAD_W + 1;

  logic [SH_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg   <= '0;
      ser_out <= STOP_LVL;
    end else if (load) begin
      ser_out <= START_LVL;
      shreg   <= {payload, STOP_LVL};
    end else if (bit_en) begin
      ser_out <= shreg[SH_W-1];
      shreg   <= {shreg[SH_W-2:0], 1'b0};
    end
  end

  p_start_r2: assert property (@(posedge clk) disable iff (rst)
    load |=> (ser_out == START_LVL));
  p_line_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(ser_out));
endmodule

// File: rtl/fss_serializer.sv
module fss_serializer #(
  parameter int PAYLOAD_W = 18
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bit_en,
  input  logic [PAYLOAD_W-1:0] data,
  input  logic                 valid,
  input  logic                 sync_req,
  output logic                 ser_out
);
  import fss_pkg::*;
  localparam int SYM_W = PAYLOAD_W + 2;

  logic                 load;
  logic                 last;
  logic [PAYLOAD_W-1:0] payload;

  fss_bit_counter #(.SYM_W(SYM_W)) u_cnt (
    .clk(clk), .rst(rst), .bit_en(bit_en), .load(load), .last(last)
  );

  fss_payload_mux #(.PAYLOAD_W(PAYLOAD_W)) u_mux (
    .data(data), .valid(valid), .sync_req(sync_req), .payload(payload)
  );

  fss_shifter #(.PAYLOAD_W(PAYLOAD_W)) u_sh (
    .clk(clk), .rst(rst), .bit_en(bit_en), .load(load),
    .payload(payload), .ser_out(ser_out)
  );

  // Stop bit leaves the shifter on the final slot of every symbol.
  p_stop_r2: assert property (@(posedge clk) disable iff (rst)
    last |=> (ser_out == STOP_LVL));
  // Boundary edge: line was low before the start bit goes out.
  p_rise_r9: assert property (@(posedge clk) disable iff (rst)
    load |=> (ser_out && !$past(ser_out)));
endmodule

// File: tb/fss_serializer_bench.sv
module fss_serializer_bench;
  localparam int PW = 18;
  localparam int SW = PW + 2;
  localparam logic [PW-1:0] SYNC_W = 18'h3FE00;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_en = 1'b0;
  logic [PW-1:0] data = '0;
  logic valid = 1'b0;
  logic sync_req = 1'b0;
  logic ser_out;

  int checks = 0;
  int errors = 0;

  logic [PW-1:0] st_data [$];
  logic          st_valid [$];
  logic          st_sync [$];
  logic          exp_q [$];

  always #4 clk = ~clk;

  fss_serializer #(.PAYLOAD_W(PW)) u_fss_serializer (
    .clk(clk), .rst(rst), .bit_en(bit_en), .data(data),
    .valid(valid), .sync_req(sync_req), .ser_out(ser_out)
  );

  // Driver: queue the stimulus and the 20 expected line bits per symbol.
  task automatic add_sym(input logic [PW-1:0] d, input logic v, input logic s);
    logic [PW-1:0] pl;
    logic [SW-1:0] sym;
    pl = s ? SYNC_W : (v ? d : '0);           // R4, R5
    sym = {1'b1, pl, 1'b0};                  // R2, R3
    st_data.push_back(d);
    st_valid.push_back(v);
    st_sync.push_back(s);
    for (int i = SW - 1; i >= 0; i--) exp_q.push_back(sym[i]);
  endtask

  task automatic apply_next();
    data = st_data.pop_front();
    valid = st_valid.pop_front();
    sync_req = st_sync.pop_front();
  endtask

  initial begin
    logic en_prev;
    logic last_out;
    logic e;
    int p;
    int cyc;
    int sym_no;

    add_sym(18'h2A5C3, 1'b1, 1'b0);
    add_sym(18'h3FFFF, 1'b1, 1'b0);
    add_sym(18'h00001, 1'b1, 1'b0);
    add_sym(18'h15555, 1'b1, 1'b1);   // R4: sync wins over valid
    add_sym(18'h0F0F0, 1'b0, 1'b0);   // R5: no valid -> zeros
    add_sym(18'h20000, 1'b1, 1'b0);
    add_sym(18'h3ABCD, 1'b0, 1'b1);   // R4
    add_sym(18'h2AAAA, 1'b1, 1'b0);
    add_sym(18'h3FFFF, 1'b0, 1'b0);   // R5
    add_sym(18'h12345, 1'b1, 1'b0);
    add_sym(18'h00000, 1'b0, 1'b1);   // R4
    add_sym(18'h3C3C3, 1'b1, 1'b0);

    apply_next();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    checks++;
    if (ser_out !== 1'b0) begin
      errors++;
      $display("FAIL R1: ser_out after reset %b, expected 0", ser_out);
    end

    en_prev = 1'b0;
    last_out = ser_out;
    p = 0;
    cyc = 0;
    sym_no = 0;
    while (exp_q.size() > 0) begin
      // Drive bit_en for the coming edge: full rate first, then one in three.
      bit_en = (sym_no < 6) ? 1'b1 : ((cyc % 3) == 0);
      en_prev = bit_en;
      last_out = ser_out;
      @(negedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        $display("FAIL watchdog: run hung");
        break;
      end
      if (en_prev) begin
        // Monitor: R2/R3/R8/R9 bit-by-bit against the scoreboard.
        e = exp_q.pop_front();
        checks++;
        if (ser_out !== e) begin
          errors++;
          $display("FAIL R8 (sym %0d slot %0d): ser_out %b, expected %b", sym_no, p, ser_out, e);
        end
        p++;
        if (p == 10) begin
          // R6: inputs flip mid-symbol and must be ignored.
          data = ~data;
          valid = ~valid;
          sync_req = ~sync_req;
        end
        if (p == SW) begin
          p = 0;
          sym_no++;
          if (st_data.size() > 0) apply_next();
          else begin
            data = '0; valid = 1'b0; sync_req = 1'b0;
          end
        end
      end else begin
        checks++;
        if (ser_out !== last_out) begin
          errors++;
          $display("FAIL R7: ser_out %b changed without enable, expected %b", ser_out, last_out);
        end
      end
    end

    // R9: trailing idle symbol begins with a start bit after the last stop bit.
    bit_en = 1'b1;
    @(negedge clk);
    checks++;
    if (ser_out !== 1'b1) begin
      errors++;
      $display("FAIL R9: ser_out %b after final stop, expected 1", ser_out);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule